// File: doc/BRIEF.md
# Averaged Deadbanded Control Potentiometer Reader

This block turns a stream of 10-bit conversions from a control potentiometer into a steady 16-bit buffer-size setting for a reverse-playback controller. Every conversion that arrives with its valid strobe is added into a 24-bit accumulator. The low byte of that accumulator holds the fractional part.

After a window of 256 conversions the upper 16 bits of the sum give the window average. The average is clamped from below to 2 and from above to a configurable ceiling. It is then compared with the setting currently held. The held setting takes the new value only when the two differ by at least the deadband, which is 2 by default. The accumulator empties after every window. Jitter of one LSB on the potentiometer therefore never reaches the output.

Top module: `potavg_reader`

## Requirements
- R1: After reset the held setting `sizeOut` equals the floor value 2, and the accumulator and window counter are empty.
- R2: `sizeOut` can change only in the cycle that follows the clock edge at which the 256th valid conversion of a window is taken. Between those edges it holds its value.
- R3: The candidate value of a window is the sum of its 256 conversions shifted right by 8 bits, which is the floor of the mean.
- R4: A candidate below 2 becomes 2.
- R5: A candidate at or above `MAX_SIZE` (default 1000) becomes `MAX_SIZE`, so `sizeOut` always lies in [2, `MAX_SIZE`].
- R6: The held setting is replaced only when the absolute difference between the clamped candidate and the held setting is at least `DEADBAND` (default 2). A difference of 1 leaves it unchanged, whether the candidate is above or below.
- R7: The accumulator is cleared at each evaluation. Each window's result depends only on that window's conversions.
- R8: Cycles with `adcValid` low are ignored. Their `adcData` is neither counted nor accumulated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adcValid | input | 1 | One-cycle strobe marking a new conversion |
| adcData | input | 10 | Unsigned conversion result |
| sizeOut | output | 16 | Held, clamped, deadbanded buffer-size setting |

## Verification
Constant windows show that the output is the mean itself. A linear ramp window with a fractional mean shows truncation rather than rounding. Windows that sit one and then two codes away from the held value, approached from above and from below, separate the deadband edge from an off-by-one compare. Windows of zeros and of full-scale codes, and a window exactly at the ceiling, exercise both clamps. A window interleaved with full-scale data on cycles without a strobe shows that unstrobed cycles leave the average untouched, and sampling just before the closing strobe shows that no early update occurs.

// File: rtl/potavg_pkg.sv
package potavg_pkg;
  // strobes passed from the window control to the datapath
  typedef struct packed {
    logic accumulate;  // add this conversion into the running sum
    logic evaluate;    // last conversion of the window: produce a result
  } potStrobe_t;
endpackage

// File: rtl/potavg_ctrl.sv
module potavg_ctrl
  import potavg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       adcValid,
  output potStrobe_t strobe
);
  localparam logic [CNT_W-1:0] LastCount = {CNT_W{1'b1}};

  logic [CNT_W-1:0] sampleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCnt <= '0;
    end else if (adcValid) begin
      sampleCnt <= sampleCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.accumulate = adcValid;
    strobe.evaluate   = adcValid && (sampleCnt == LastCount);
  end
endmodule

// File: rtl/potavg_datapath.sv
module potavg_datapath
  import potavg_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int ACC_W    = 24,
  parameter int FRAC_W   = 8,
  parameter int MIN_SIZE = 2,
  parameter int MAX_SIZE = 1000,
  parameter int DEADBAND = 2,
  localparam int OUT_W   = ACC_W - FRAC_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  potStrobe_t          strobe,
  input  logic [SAMPLE_W-1:0] adcData,
  output logic [OUT_W-1:0]    sizeOut
);
  localparam logic [OUT_W-1:0] MinL  = MIN_SIZE[OUT_W-1:0];
  localparam logic [OUT_W-1:0] MaxL  = MAX_SIZE[OUT_W-1:0];
  localparam logic [OUT_W:0]   BandL = DEADBAND[OUT_W:0];

  logic [ACC_W-1:0] accReg;
  logic [ACC_W-1:0] accNext;
  logic [OUT_W-1:0] average;
  logic [OUT_W-1:0] clamped;
  logic [OUT_W:0]   distance;
  logic [OUT_W-1:0] heldSize;

  always_comb begin
    accNext = accReg + {{(ACC_W-SAMPLE_W){1'b0}}, adcData};
    average = accNext[ACC_W-1:FRAC_W];
    if (average < MinL) begin
      clamped = MinL;
    end else if (average >= MaxL) begin
      clamped = MaxL;
    end else begin
      clamped = average;
    end
    if (clamped >= heldSize) begin
      distance = {1'b0, clamped} - {1'b0, heldSize};
    end else begin
      distance = {1'b0, heldSize} - {1'b0, clamped};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg   <= '0;
      heldSize <= MinL;
    end else if (strobe.evaluate) begin
      accReg <= '0;
      if (distance >= BandL) begin
        heldSize <= clamped;
      end
    end else if (strobe.accumulate) begin
      accReg <= accNext;
    end
  end

  assign sizeOut = heldSize;
endmodule

// File: rtl/potavg_reader.sv
module potavg_reader
  import potavg_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int CNT_W    = 8,
  parameter int ACC_W    = 24,
  parameter int MIN_SIZE = 2,
  parameter int MAX_SIZE = 1000,
  parameter int DEADBAND = 2,
  localparam int OUT_W   = ACC_W - CNT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                adcValid,
  input  logic [SAMPLE_W-1:0] adcData,
  output logic [OUT_W-1:0]    sizeOut
);
  potStrobe_t strobe;

  potavg_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .adcValid (adcValid),
    .strobe   (strobe)
  );

  potavg_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W),
    .FRAC_W   (CNT_W),
    .MIN_SIZE (MIN_SIZE),
    .MAX_SIZE (MAX_SIZE),
    .DEADBAND (DEADBAND)
  ) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .adcData (adcData),
    .sizeOut (sizeOut)
  );
endmodule

// File: rtl/potavg_checker.sv
module potavg_checker #(
  parameter int CNT_W    = 8,
  parameter int OUT_W    = 16,
  parameter int MIN_SIZE = 2,
  parameter int MAX_SIZE = 1000,
  parameter int DEADBAND = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             adcValid,
  input logic [OUT_W-1:0] sizeOut
);
  localparam logic [OUT_W-1:0] MinL  = MIN_SIZE[OUT_W-1:0];
  localparam logic [OUT_W-1:0] MaxL  = MAX_SIZE[OUT_W-1:0];
  localparam logic [OUT_W:0]   BandL = DEADBAND[OUT_W:0];

  logic [CNT_W-1:0] seenCnt;
  logic [OUT_W-1:0] prevSize;
  logic             prevValid;
  logic             prevClose;
  logic [OUT_W:0]   jump;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenCnt   <= '0;
      prevSize  <= MinL;
      prevValid <= 1'b0;
      prevClose <= 1'b0;
    end else begin
      if (adcValid) seenCnt <= seenCnt + 1'b1;
      prevSize  <= sizeOut;
      prevValid <= adcValid;
      prevClose <= adcValid && (seenCnt == {CNT_W{1'b1}});
    end
  end

  assign jump = (sizeOut >= prevSize) ? ({1'b0, sizeOut} - {1'b0, prevSize})
                                      : ({1'b0, prevSize} - {1'b0, sizeOut});

  // R4 and R5: setting stays inside the clamp range
  p_in_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sizeOut >= MinL) && (sizeOut <= MaxL));

  p_update_on_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sizeOut != prevSize) |-> prevClose);

  p_deadband_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sizeOut != prevSize) |-> (jump >= BandL));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !prevValid |-> (sizeOut == prevSize));
endmodule

bind potavg_reader potavg_checker #(
  .CNT_W    (CNT_W),
  .OUT_W    (OUT_W),
  .MIN_SIZE (MIN_SIZE),
  .MAX_SIZE (MAX_SIZE),
  .DEADBAND (DEADBAND)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .adcValid (adcValid),
  .sizeOut  (sizeOut)
);

// File: tb/potavg_reader_tb_top.sv
module potavg_reader_tb_top;
  localparam int MaxSize = 1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adcValid = 1'b0;
  logic [9:0]  adcData = '0;
  logic [15:0] sizeOut;

  int checks = 0;
  int errors = 0;
  int expHeld = 2;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  potavg_reader dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .adcValid (adcValid),
    .adcData  (adcData),
    .sizeOut  (sizeOut)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: sizeOut=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // one window: data = base + step*i clipped to 0..1023, optional idle gaps
  task automatic runWindow(input string req, input int base, input int step, input bit gaps);
    int sum = 0;
    int avg;
    int diff;
    for (int i = 0; i < 256; i++) begin
      int v = base + step * i;
      if (v > 1023) v = 1023;
      if (v < 0) v = 0;
      if (gaps) begin
        @(negedge clk);
        adcValid = 1'b0;
        adcData  = 10'd1023;
        @(negedge clk);
        adcData  = 10'd0;
      end
      @(negedge clk);
      if (i == 255) check({req, " R2 no early update"}, sizeOut, expHeld);
      adcValid = 1'b1;
      adcData  = v[9:0];
      sum += v;
    end
    @(negedge clk);
    adcValid = 1'b0;
    adcData  = '0;
    avg = sum >> 8;
    if (avg < 2) avg = 2;
    else if (avg >= MaxSize) avg = MaxSize;
    diff = (avg > expHeld) ? avg - expHeld : expHeld - avg;
    if (diff >= 2) expHeld = avg;
    check(req, sizeOut, expHeld);
  endtask

  task automatic testReset();
    check("R1 reset value", sizeOut, 2);
  endtask

  task automatic testConstant();
    runWindow("R3 constant 500", 500, 0, 1'b0);
  endtask

  task automatic testRamp();
    // sum 3*32640 = 97920, mean 382.5 truncates to 382
    runWindow("R3 R7 ramp truncation", 0, 3, 1'b0);
    check("R3 ramp value", sizeOut, 382);
  endtask

  task automatic testDeadband();
    runWindow("R6 up by one held", 383, 0, 1'b0);
    check("R6 held 382", sizeOut, 382);
    runWindow("R6 up by two taken", 384, 0, 1'b0);
    check("R6 moved 384", sizeOut, 384);
    runWindow("R6 down by one held", 383, 0, 1'b0);
    check("R6 held 384", sizeOut, 384);
    runWindow("R6 down by two taken", 382, 0, 1'b0);
  endtask

  task automatic testClamps();
    runWindow("R4 zeros clamp", 0, 0, 1'b0);
    check("R4 floor 2", sizeOut, 2);
    runWindow("R5 full scale clamp", 1023, 0, 1'b0);
    check("R5 ceiling", sizeOut, MaxSize);
    runWindow("R5 mid 990", 990, 0, 1'b0);
    runWindow("R5 exactly ceiling", MaxSize, 0, 1'b0);
    check("R5 at ceiling", sizeOut, MaxSize);
  endtask

  task automatic testGaps();
    runWindow("R8 gapped window", 600, 0, 1'b1);
    check("R8 ignores idle data", sizeOut, 600);
    repeat (50) @(negedge clk);
    check("R2 idle stable", sizeOut, 600);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testConstant();
    testRamp();
    testDeadband();
    testClamps();
    testGaps();
    runWindow("R7 fresh window 123", 123, 0, 1'b0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule